// File: doc/BRIEF.md
# Fracturable Subword SIMD Multiplier Lane

This block is the multiply unit of one 32-bit vector lane. A two-bit size control picks the element width. In word mode it forms one 32x32 product. In halfword mode it forms two independent 16x16 products. In byte mode it forms four independent 8x8 products. A signed/unsigned control applies to every element. A high/low control chooses which half of each double-width product goes back into that element's own slot of the 32-bit result.

Each element size has its own bank of multipliers. Every multiplier is wired straight to its bit field of the registered operands. The word multiplier and the lowest halfword and byte multipliers all take the least significant end of the operands. The operand path has no adders and no steering multiplexers. The only selection is a mux at the output, driven by the size and half controls.

The lane is pipelined. An input beat flagged valid produces its result two clock edges later, and a valid flag travels with it. Between valid results the output register keeps its last value.

Top module: `simd_mul_lane`

## Requirements
- R1: While the active-low reset is asserted, out_valid is 0 and result is 0.
- R2: out_valid equals the in_valid sampled two rising edges earlier. The result of that beat is on result in the same cycle.
- R3: With size_mode 2'b00, result is the lower (take_high=0) or upper (take_high=1) 32 bits of the 64-bit product op_a*op_b.
- R4: With size_mode 2'b01, slot k (k=0 for bits 15:0, k=1 for bits 31:16) holds the selected half of the 32-bit product of the operands' halfword k.
- R5: With size_mode 2'b10, slot k (bits 8k+7:8k, k=0..3) holds the selected half of the 16-bit product of the operands' byte k.
- R6: With is_signed=1, each element's operands are treated as two's complement and sign-extended. With is_signed=0 they are zero-extended.
- R7: take_high=0 returns the lower half of each product at the element width, and take_high=1 returns the upper half.
- R8: In halfword and byte modes, no element's operands or carries affect another element's slot.
- R9: When no valid beat reaches the output stage, result keeps its previous value.
- R10: size_mode 2'b11 behaves exactly as word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat is valid |
| size_mode | input | 2 | Element size: 00 word, 01 halfword, 10 byte, 11 word |
| is_signed | input | 1 | 1 = signed elements, 0 = unsigned |
| take_high | input | 1 | 1 = upper half of each product, 0 = lower half |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result beat is valid |
| result | output | 32 | Packed element results |

## Verification
The hardest case to reach is an upper-half result in signed byte or halfword mode where the sign extension decides the upper bits. Uniform random operands rarely set the top bit of every element at once. Such cases also expose any carry that leaks into a neighbouring slot.

Directed beats therefore use all-ones, 0x80-style minimum values, and operands that are zero in one element but full in the next. These are applied under every combination of size, sign and half. Random beats with idle gaps then cover the pipelined flow and the hold behaviour.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
   typedef enum logic [1:0] {
      SZ_WORD = 2'b00,
      SZ_HALF = 2'b01,
      SZ_BYTE = 2'b10,
      SZ_ALTW = 2'b11
   } size_e;
endpackage

// File: rtl/mul_elem.sv
module mul_elem #(
   parameter int W = 8
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           sgn,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;
   logic signed [PW-1:0] xa;
   logic signed [PW-1:0] xb;
   logic signed [PW-1:0] full;

   // Extend to the product width. The exact product always fits in PW bits.
   assign xa   = {{W{sgn & a[W-1]}}, a};
   assign xb   = {{W{sgn & b[W-1]}}, b};
   assign full = xa * xb;
   assign prod = full;
endmodule

// File: rtl/mul_bank.sv
module mul_bank #(
   parameter int LANE_W = 32,
   parameter int SLOTS  = 1
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic              sgn,
   output logic [LANE_W-1:0] lo,
   output logic [LANE_W-1:0] hi
);
   localparam int SW = LANE_W / SLOTS;

   if (LANE_W % SLOTS != 0) begin : g_bad_split
      $error("mul_bank: LANE_W must divide evenly into SLOTS");
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_elem
      logic [2*SW-1:0] p;
      mul_elem #(.W(SW)) u_elem (
         .a    (a[k*SW +: SW]),
         .b    (b[k*SW +: SW]),
         .sgn  (sgn),
         .prod (p)
      );
      assign lo[k*SW +: SW] = p[SW-1:0];
      assign hi[k*SW +: SW] = p[2*SW-1:SW];
   end
endmodule

// File: rtl/result_pick.sv
module result_pick
   import simd_mul_pkg::*;
#(
   parameter int LANE_W = 32
) (
   input  size_e             mode,
   input  logic              take_high,
   input  logic [LANE_W-1:0] w_lo,
   input  logic [LANE_W-1:0] w_hi,
   input  logic [LANE_W-1:0] h_lo,
   input  logic [LANE_W-1:0] h_hi,
   input  logic [LANE_W-1:0] b_lo,
   input  logic [LANE_W-1:0] b_hi,
   output logic [LANE_W-1:0] y
);
   always_comb begin
      unique case (mode)
         SZ_HALF: y = take_high ? h_hi : h_lo;
         SZ_BYTE: y = take_high ? b_hi : b_lo;
         default: y = take_high ? w_hi : w_lo;
      endcase
   end
endmodule

// File: rtl/simd_mul_lane.sv
module simd_mul_lane
   import simd_mul_pkg::*;
#(
   parameter int LANE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        size_mode,
   input  logic              is_signed,
   input  logic              take_high,
   input  logic [LANE_W-1:0] op_a,
   input  logic [LANE_W-1:0] op_b,
   output logic              out_valid,
   output logic [LANE_W-1:0] result
);
   localparam int N_WORD = 1;
   localparam int N_HALF = 2;
   localparam int N_BYTE = 4;

   if (LANE_W % N_BYTE != 0 || LANE_W < 8) begin : g_bad_width
      $error("simd_mul_lane: LANE_W must be a multiple of 4 and at least 8");
   end

   // Stage 1: capture the operands and controls of a valid beat
   logic              s1_v;
   logic [LANE_W-1:0] s1_a, s1_b;
   size_e             s1_mode;
   logic              s1_sgn, s1_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_a    <= '0;
         s1_b    <= '0;
         s1_mode <= SZ_WORD;
         s1_sgn  <= 1'b0;
         s1_hi   <= 1'b0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_a    <= op_a;
            s1_b    <= op_b;
            s1_mode <= size_e'(size_mode);
            s1_sgn  <= is_signed;
            s1_hi   <= take_high;
         end
      end
   end

   // One bank per element size, each wired straight to its operand fields
   logic [LANE_W-1:0] w_lo, w_hi, h_lo, h_hi, b_lo, b_hi;

   mul_bank #(.LANE_W(LANE_W), .SLOTS(N_WORD)) u_word (
      .a(s1_a), .b(s1_b), .sgn(s1_sgn), .lo(w_lo), .hi(w_hi));
   mul_bank #(.LANE_W(LANE_W), .SLOTS(N_HALF)) u_half (
      .a(s1_a), .b(s1_b), .sgn(s1_sgn), .lo(h_lo), .hi(h_hi));
   mul_bank #(.LANE_W(LANE_W), .SLOTS(N_BYTE)) u_byte (
      .a(s1_a), .b(s1_b), .sgn(s1_sgn), .lo(b_lo), .hi(b_hi));

   logic [LANE_W-1:0] picked;

   result_pick #(.LANE_W(LANE_W)) u_pick (
      .mode(s1_mode), .take_high(s1_hi),
      .w_lo(w_lo), .w_hi(w_hi), .h_lo(h_lo), .h_hi(h_hi),
      .b_lo(b_lo), .b_hi(b_hi), .y(picked));

   // Stage 2: output register, updated only by a valid beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= s1_v;
         if (s1_v) result <= picked;
      end
   end
endmodule

// File: rtl/simd_mul_lane_chk.sv
module simd_mul_lane_chk #(
   parameter int LANE_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        size_mode,
   input logic [LANE_W-1:0] op_a,
   input logic [LANE_W-1:0] op_b,
   input logic              take_high,
   input logic              out_valid,
   input logic [LANE_W-1:0] result
);
   localparam int HW = LANE_W / 2;
   localparam int BW = LANE_W / 4;

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= 2'd0;
      else if (since_rst != 3) since_rst <= since_rst + 2'd1;
   end

   logic deep;
   assign deep = (since_rst >= 2'd2);

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      deep |-> (out_valid == $past(in_valid, 2)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (deep && !$past(in_valid, 2)) |-> $stable(result));

   assert_word_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (deep && $past(in_valid, 2) && $past(size_mode, 2) == 2'b00 && !$past(take_high, 2))
      |-> (result == LANE_W'($past(op_a, 2) * $past(op_b, 2))));

   assert_byte_isolation_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (deep && $past(in_valid, 2) && $past(size_mode, 2) == 2'b10 && $past(op_a[BW-1:0], 2) == '0)
      |-> (result[BW-1:0] == '0));

   assert_half_isolation_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (deep && $past(in_valid, 2) && $past(size_mode, 2) == 2'b01 && $past(op_b[LANE_W-1:HW], 2) == '0)
      |-> (result[LANE_W-1:HW] == '0));
endmodule

bind simd_mul_lane simd_mul_lane_chk #(.LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_mode(size_mode),
   .op_a(op_a), .op_b(op_b), .take_high(take_high),
   .out_valid(out_valid), .result(result));

// File: tb/tb_simd_mul_lane.sv
`timescale 1ns/1ps
module tb_simd_mul_lane;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  size_mode = 2'b00;
   logic        is_signed = 1'b0;
   logic        take_high = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        out_valid;
   logic [31:0] result;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   simd_mul_lane dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_mode(size_mode),
      .is_signed(is_signed), .take_high(take_high), .op_a(op_a), .op_b(op_b),
      .out_valid(out_valid), .result(result));

   // Reference for R3..R8 and R10: per-element extension and multiply
   function automatic logic [31:0] model(input logic [1:0] m, input bit s, input bit h,
                                         input logic [31:0] a, input logic [31:0] b);
      int w;
      int n;
      logic [31:0] r;
      w = (m == 2'b01) ? 16 : (m == 2'b10) ? 8 : 32;
      n = 32 / w;
      r = '0;
      for (int k = 0; k < n; k++) begin
         logic signed [65:0] ea, eb, p;
         logic [65:0] mask, slot;
         mask = (66'd1 << w) - 66'd1;
         ea = (66'(a) >> (k * w)) & mask;
         eb = (66'(b) >> (k * w)) & mask;
         if (s && ea[w-1]) ea = ea - (66'sd1 <<< w);
         if (s && eb[w-1]) eb = eb - (66'sd1 <<< w);
         p = ea * eb;
         slot = h ? ((66'(p) >> w) & mask) : (66'(p) & mask);
         r = r | (32'(slot) << (k * w));
      end
      return r;
   endfunction

   function automatic string tag_of(input logic [1:0] m, input bit s, input bit h);
      string t;
      t = (m == 2'b00) ? "R3" : (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R10";
      if (s) t = {t, "/R6"};
      if (h) t = {t, "/R7"};
      if (m == 2'b01 || m == 2'b10) t = {t, "/R8"};
      return t;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected values of the beats driven one and two negedges ago
   bit          d1_v = 0, d2_v = 0;
   logic [31:0] d1_r = '0, d2_r = '0;
   string       d1_t = "", d2_t = "";
   logic [31:0] exp_res = '0;

   task automatic step(input bit v, input logic [1:0] m, input bit s, input bit h,
                       input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      check("R2", 32'(out_valid), 32'(d2_v));
      if (d2_v) begin
         exp_res = d2_r;
         check(d2_t, result, exp_res);
      end else begin
         check("R9", result, exp_res);
      end
      d2_v = d1_v; d2_r = d1_r; d2_t = d1_t;
      d1_v = v;
      d1_r = model(m, s, h, a, b);
      d1_t = tag_of(m, s, h);
      in_valid = v; size_mode = m; is_signed = s; take_high = h; op_a = a; op_b = b;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check("R1", 32'(out_valid), 32'd0);
      check("R1", result, 32'd0);
      rst_n = 1'b1;

      // Directed corners: every size, sign and half combination
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int h = 0; h < 2; h++) begin
               step(1, 2'(m), 1'(s), 1'(h), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
               step(1, 2'(m), 1'(s), 1'(h), 32'h8080_8000, 32'h8080_8000);
               step(1, 2'(m), 1'(s), 1'(h), 32'h0000_FFFF, 32'hFFFF_FFFF);
               step(1, 2'(m), 1'(s), 1'(h), 32'hFF00_FF00, 32'h7F01_7F01);
               step(1, 2'(m), 1'(s), 1'(h), 32'h7FFF_8001, 32'h8000_7FFF);
            end

      // Idle beats with garbage data: result must hold (R9)
      for (int i = 0; i < 4; i++)
         step(0, 2'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);

      // Random traffic with gaps
      for (int i = 0; i < 3000; i++)
         step(($urandom_range(0, 9) < 8), 2'($urandom_range(0, 3)), 1'($urandom),
              1'($urandom), $urandom, $urandom);

      step(0, 2'b00, 0, 0, '0, '0);
      step(0, 2'b00, 0, 0, '0, '0);
      step(0, 2'b00, 0, 0, '0, '0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule